// File: doc/BRIEF.md
# Maskable Event Interrupt Aggregator with Banked Endpoint Suspend Tracking

This block gathers three event conditions of a packet-processing accelerator into one level-sensitive interrupt line. Two conditions come from strobes raised by an embedded microcontroller. The third reports that traffic has reached an endpoint that is suspended and needs a wakeup. Each condition has a raw status bit, an enable bit and a write-one-to-clear acknowledge bit. Software can mask and acknowledge each condition on its own.

Suspend reporting is tracked per endpoint. The endpoints are grouped into 32-bit bank words: endpoint n sits in bank n/32 at bit n%32. Each bank has three registers: an enable register, an info register that holds status, and an acknowledge register that clears info. When an accepted suspend event arrives, the summary suspend bit is raised. Acknowledging that summary bit also empties every info bank.

A legacy mode input freezes the per-endpoint enable registers and makes the per-bank acknowledge writes do nothing. In this mode every endpoint is treated as enabled for reporting.

Top module: `evt_irq_hub`

## Requirements
- R1: After reset, the summary status, the summary enable, every suspend enable and every suspend info register read zero, and `irq` is low. Summary status shows a condition even while its enable bit is clear.
- R2: `irq` is high exactly while some summary status bit and its enable bit are both set. It goes low in the cycle after the write that clears the last such pair.
- R3: Writing the summary acknowledge register (address 0x02) clears each status bit written with one. Bits written with zero keep their value.
- R4: A pulse on `mcu_evt[0]` sets summary bit 0, and a pulse on `mcu_evt[1]` sets summary bit 1. Summary bit 2 is the suspend condition.
- R5: A suspend event for endpoint n, where n's enable bit is set, sets info bit n%32 of bank n/32 and sets summary bit 2.
- R6: Outside legacy mode, a suspend event for an endpoint whose enable bit is clear changes neither the info registers nor the summary status.
- R7: Writing the suspend acknowledge register of bank b (address 0x30+b) clears the info bits written with one. Other banks and the summary status are left unchanged.
- R8: Writing one to bit 2 of the summary acknowledge register clears all suspend info bits in every bank, in both modes.
- R9: If an event sets a summary or info bit in the same cycle that a write clears that bit, the bit ends up set.
- R10: With `legacy_mode` high, writes to the suspend enable registers and to the per-bank acknowledge registers have no effect. Suspend events are accepted for every existing endpoint.
- R11: Endpoint bits at or above EP_COUNT read zero, ignore writes and ignore suspend events. Summary enable bits above bit 2 read zero.
- R12: The address map is: status 0x00, enable 0x01, acknowledge 0x02, suspend enable 0x10+b, suspend info 0x20+b, suspend acknowledge 0x30+b. Acknowledge and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| legacy_mode | input | 1 | Selects legacy suspend handling |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| mcu_evt | input | 2 | Microcontroller event strobes |
| susp_evt | input | 1 | Suspend event strobe |
| susp_ep | input | EP_W | Endpoint index of the suspend event |
| irq | output | 1 | Level interrupt output |

## Verification
Reads are combinational, so any corrupted status, enable or info bit shows on `reg_rdata` in the cycle after the edge that corrupted it. A wrong summary or enable bit also shows at once as a wrong level on `irq`. A bank that decodes the endpoint index wrongly leaves the info bit in the wrong word, which the next read exposes. A set event that loses to a clear, or a legacy write that gets through, leaves a readable difference one cycle later.

// File: rtl/evt_irq_pkg.sv
// Shared constants for the event interrupt aggregator.
// Assumes a 6-bit word address: the upper two bits select a page,
// the lower four select a bank inside the page (at most 16 banks).
package evt_irq_pkg;
    localparam int SUM_W    = 3;
    localparam int ADDR_W   = 6;
    localparam int BANK_SEL_W = 4;

    typedef enum logic [1:0] {
        SRC_MCU_A   = 2'd0,
        SRC_MCU_B   = 2'd1,
        SRC_SUSPEND = 2'd2
    } sum_src_e;

    localparam logic [ADDR_W-1:0] A_STAT = 6'h00;
    localparam logic [ADDR_W-1:0] A_EN   = 6'h01;
    localparam logic [ADDR_W-1:0] A_ACK  = 6'h02;

    localparam logic [1:0] PG_SUSP_EN   = 2'd1;
    localparam logic [1:0] PG_SUSP_INFO = 2'd2;
    localparam logic [1:0] PG_SUSP_ACK  = 2'd3;
endpackage

// File: rtl/evt_irq_susp_bank.sv
// One 32-endpoint suspend bank: enable and info registers.
// Assumes the top decodes the bank address and passes in a
// bank-local bit index. Bits past EP_COUNT are held at zero.
module evt_irq_susp_bank #(
    parameter int BANK_IDX = 0,
    parameter int EP_COUNT = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        legacy_i,
    input  logic        en_wr_i,
    input  logic        ack_wr_i,
    input  logic [31:0] wdata_i,
    input  logic        all_clr_i,
    input  logic        set_req_i,
    input  logic [4:0]  set_bit_i,
    output logic [31:0] en_o,
    output logic [31:0] info_o,
    output logic        set_acc_o
);
    function automatic logic [31:0] live_bits();
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++)
            if (BANK_IDX * 32 + i < EP_COUNT) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [31:0] LIVE = live_bits();

    logic [31:0] en_q, info_q, set_vec, clr_vec;

    // Accept a suspend event only for a live, enabled (or legacy) endpoint
    assign set_acc_o = set_req_i && LIVE[set_bit_i] && (legacy_i || en_q[set_bit_i]);

    // Build one-hot set vector and clear vector for this cycle
    always_comb begin
        set_vec = '0;
        if (set_acc_o) set_vec[set_bit_i] = 1'b1;
        if (all_clr_i)                  clr_vec = '1;
        else if (ack_wr_i && !legacy_i) clr_vec = wdata_i;
        else                            clr_vec = '0;
    end

    // Enable register: frozen in legacy mode
    always_ff @(posedge clk) begin
        if (!rst_n)                     en_q <= '0;
        else if (en_wr_i && !legacy_i)  en_q <= wdata_i & LIVE;
    end

    // Info register: clear first, then set, so a set wins
    always_ff @(posedge clk) begin
        if (!rst_n) info_q <= '0;
        else        info_q <= ((info_q & ~clr_vec) | set_vec) & LIVE;
    end

    assign en_o   = en_q;
    assign info_o = info_q;

    AST_LEGACY_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) legacy_i |=> $stable(en_q)); // R10
    AST_LEGACY_ACK_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (legacy_i && !all_clr_i) |=> ((info_q & $past(info_q)) == $past(info_q))); // R10
    AST_BLOCKED_SET: assert property (@(posedge clk) disable iff (!rst_n) (set_req_i && !legacy_i && !en_q[set_bit_i] && !info_q[set_bit_i]) |=> !info_q[$past(set_bit_i)]); // R6
    AST_ALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (all_clr_i && !set_req_i) |=> (info_q == '0)); // R8
endmodule

// File: rtl/evt_irq_summary.sv
// Summary status/enable pair for the three event conditions and
// the level interrupt. Assumes set strobes already qualified.
module evt_irq_summary
    import evt_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] set_i,
    input  logic             en_wr_i,
    input  logic             ack_wr_i,
    input  logic [SUM_W-1:0] wdata_i,
    output logic [SUM_W-1:0] stat_o,
    output logic [SUM_W-1:0] en_o,
    output logic             irq_o
);
    logic [SUM_W-1:0] stat_q, en_q, clr_vec;

    // Acknowledge vector from write-one-to-clear data
    always_comb clr_vec = ack_wr_i ? wdata_i : '0;

    // Status: clear then set, so a same-cycle event is kept
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_vec) | set_i;
    end

    // Enable register written whole
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_wr_i) en_q <= wdata_i;
    end

    assign irq_o  = |(stat_q & en_q);
    assign stat_o = stat_q;
    assign en_o   = en_q;

    generate
        for (genvar k = 0; k < SUM_W; k++) begin : g_chk
            AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) set_i[k] |=> stat_q[k]); // R9
        end
    endgenerate
    AST_IRQ_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $fell(irq_o) |-> $past(en_wr_i || ack_wr_i)); // R2
    AST_ACK_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !ack_wr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R3
endmodule

// File: rtl/evt_irq_hub.sv
// Top of the event interrupt aggregator: address decode, read mux,
// a generated array of suspend banks and the summary register pair.
// Assumes single-cycle register writes; reads are combinational.
module evt_irq_hub
    import evt_irq_pkg::*;
#(
    parameter int EP_COUNT = 40,
    parameter int BANKS    = (EP_COUNT + 31) / 32,
    parameter int EP_W     = $clog2(BANKS * 32)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              legacy_mode,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [1:0]        mcu_evt,
    input  logic              susp_evt,
    input  logic [EP_W-1:0]   susp_ep,
    output logic              irq
);
    logic [1:0]            page;
    logic [BANK_SEL_W-1:0] bsel;
    logic [31:0]           bank_en  [BANKS];
    logic [31:0]           bank_inf [BANKS];
    logic [BANKS-1:0]      bank_acc;
    logic [SUM_W-1:0]      sum_stat, sum_en, sum_set;
    logic                  all_clr;

    assign page    = reg_addr[ADDR_W-1:ADDR_W-2];
    assign bsel    = reg_addr[BANK_SEL_W-1:0];
    assign all_clr = reg_wr && (reg_addr == A_ACK) && reg_wdata[SRC_SUSPEND];

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            logic hit, req;
            assign hit = (int'(bsel) == b);
            assign req = susp_evt && ((int'(susp_ep) / 32) == b);
            evt_irq_susp_bank #(.BANK_IDX(b), .EP_COUNT(EP_COUNT)) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .legacy_i  (legacy_mode),
                .en_wr_i   (reg_wr && page == PG_SUSP_EN && hit),
                .ack_wr_i  (reg_wr && page == PG_SUSP_ACK && hit),
                .wdata_i   (reg_wdata),
                .all_clr_i (all_clr),
                .set_req_i (req),
                .set_bit_i (susp_ep[4:0]),
                .en_o      (bank_en[b]),
                .info_o    (bank_inf[b]),
                .set_acc_o (bank_acc[b])
            );
        end
    endgenerate

    // Summary set strobes: microcontroller events and any accepted suspend
    always_comb begin
        sum_set = '0;
        sum_set[SRC_MCU_A]   = mcu_evt[0];
        sum_set[SRC_MCU_B]   = mcu_evt[1];
        sum_set[SRC_SUSPEND] = |bank_acc;
    end

    evt_irq_summary u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (sum_set),
        .en_wr_i  (reg_wr && reg_addr == A_EN),
        .ack_wr_i (reg_wr && reg_addr == A_ACK),
        .wdata_i  (reg_wdata[SUM_W-1:0]),
        .stat_o   (sum_stat),
        .en_o     (sum_en),
        .irq_o    (irq)
    );

    // Read mux: write-only and unmapped locations return zero
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_STAT)    reg_rdata = {{(32-SUM_W){1'b0}}, sum_stat};
        else if (reg_addr == A_EN) reg_rdata = {{(32-SUM_W){1'b0}}, sum_en};
        else begin
            for (int b = 0; b < BANKS; b++) begin
                if (int'(bsel) == b) begin
                    if (page == PG_SUSP_EN)   reg_rdata = bank_en[b];
                    if (page == PG_SUSP_INFO) reg_rdata = bank_inf[b];
                end
            end
        end
    end

    AST_SUSP_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n) (|bank_acc) |=> sum_stat[SRC_SUSPEND]); // R5
    AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(bank_acc)); // R5
endmodule

// File: tb/sim_evt_irq_hub.sv
module sim_evt_irq_hub;
    localparam int EP_COUNT = 40;
    localparam int EP_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic legacy_mode = 1'b0;
    logic reg_wr = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0] mcu_evt = '0;
    logic susp_evt = 1'b0;
    logic [EP_W-1:0] susp_ep = '0;
    logic irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    evt_irq_hub #(.EP_COUNT(EP_COUNT)) u0 (
        .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mcu_evt(mcu_evt), .susp_evt(susp_evt),
        .susp_ep(susp_ep), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic susp(input int ep);
        @(negedge clk);
        susp_evt = 1'b1; susp_ep = EP_W'(ep);
        @(negedge clk);
        susp_evt = 1'b0;
    endtask

    task automatic mcu(input logic [1:0] v);
        @(negedge clk);
        mcu_evt = v;
        @(negedge clk);
        mcu_evt = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(6'h00, d); check("R1 status after reset", d, 0);
        rd(6'h01, d); check("R1 enable after reset", d, 0);
        rd(6'h10, d); check("R1 suspend enable after reset", d, 0);
        rd(6'h21, d); check("R1 suspend info after reset", d, 0);
        check("R1 irq after reset", {31'b0, irq}, 0);
    endtask

    task automatic t_summary();
        logic [31:0] d;
        mcu(2'b01);
        rd(6'h00, d); check("R4 mcu0 sets bit0 (R1 raw while masked)", d, 32'h1);
        check("R1 irq low while masked", {31'b0, irq}, 0);
        wr(6'h01, 32'hFF);
        rd(6'h01, d); check("R11 enable upper bits read zero", d, 32'h7);
        check("R2 irq high when enabled", {31'b0, irq}, 1);
        mcu(2'b10);
        rd(6'h00, d); check("R4 mcu1 sets bit1", d, 32'h3);
        wr(6'h02, 32'h0);
        rd(6'h00, d); check("R3 ack zero keeps bits", d, 32'h3);
        wr(6'h02, 32'h1);
        rd(6'h00, d); check("R3 ack bit0 only", d, 32'h2);
        check("R2 irq still high for bit1", {31'b0, irq}, 1);
        wr(6'h02, 32'h2);
        check("R2 irq low next cycle after last clear", {31'b0, irq}, 0);
        rd(6'h02, d); check("R12 ack reads zero", d, 0);
    endtask

    task automatic t_suspend();
        logic [31:0] d;
        wr(6'h10, 32'h0000_0008);
        wr(6'h11, 32'hFFFF_FFFF);
        rd(6'h11, d); check("R11 bank1 enable dead bits", d, 32'h0000_00FF);
        susp(3);
        rd(6'h20, d); check("R5 info ep3", d, 32'h8);
        rd(6'h00, d); check("R5 summary suspend bit", d, 32'h4);
        check("R2 irq with suspend enabled", {31'b0, irq}, 1);
        susp(5);
        rd(6'h20, d); check("R6 disabled ep5 ignored", d, 32'h8);
        susp(33);
        rd(6'h21, d); check("R5 info ep33 in bank1", d, 32'h2);
        susp(45);
        rd(6'h21, d); check("R11 event beyond count ignored", d, 32'h2);
        wr(6'h30, 32'h8);
        rd(6'h20, d); check("R7 bank0 ack clears", d, 0);
        rd(6'h21, d); check("R7 bank1 untouched", d, 32'h2);
        rd(6'h00, d); check("R7 summary untouched", d, 32'h4);
        wr(6'h02, 32'h4);
        rd(6'h21, d); check("R8 summary ack wipes info", d, 0);
        rd(6'h00, d); check("R8 summary bit cleared", d, 0);
    endtask

    task automatic t_race();
        logic [31:0] d;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 6'h02; reg_wdata = 32'h5;
        susp_evt = 1'b1; susp_ep = 6'd3; mcu_evt = 2'b01;
        @(negedge clk);
        reg_wr = 1'b0; susp_evt = 1'b0; mcu_evt = '0;
        rd(6'h20, d); check("R9 info set wins over wipe", d, 32'h8);
        rd(6'h00, d); check("R9 summary set wins over ack", d, 32'h5);
        wr(6'h02, 32'h7);
        rd(6'h20, d); check("R8 cleanup", d, 0);
    endtask

    task automatic t_legacy();
        logic [31:0] d;
        legacy_mode = 1'b1;
        wr(6'h10, 32'h10);
        rd(6'h10, d); check("R10 enable write ignored", d, 32'h8);
        susp(7);
        rd(6'h20, d); check("R10 event accepted without enable", d, 32'h80);
        wr(6'h30, 32'h80);
        rd(6'h20, d); check("R10 bank ack ignored", d, 32'h80);
        wr(6'h02, 32'h4);
        rd(6'h20, d); check("R8 summary ack wipes in legacy", d, 0);
        legacy_mode = 1'b0;
    endtask

    task automatic t_map();
        logic [31:0] d;
        rd(6'h3F, d); check("R12 unmapped reads zero", d, 0);
        rd(6'h12, d); check("R12 absent bank reads zero", d, 0);
        rd(6'h30, d); check("R12 suspend ack reads zero", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_summary();
        t_suspend();
        t_race();
        t_legacy();
        t_map();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule